// File: doc/BRIEF.md
# Privilege-Aware Bank Translator

This block sits between a small 8-bit processor core and a group of 256-byte memory banks. Each access from the core carries an 8-bit address, an access kind and the current processor status byte. The block turns these into a 4-bit physical bank number and an 8-bit offset, plus read and write strobes for the memory.

The active code bank comes from a 3-bit field of the status byte. The lower half of the code banks holds privileged system code. While one of them runs, the core works with split instruction and data memories. Ordinary data reads and writes go to a dedicated system data bank. A privileged steering register can point those data accesses at a user bank or at the I/O page instead. The upper half of the code banks holds user programs, and each one keeps its code and data in the same bank. A constant-load access always reads the active code bank.

The steering register appears at the top offset of the data space, but only for system code. User code sees that offset as ordinary memory. The register takes a write in the cycle it is presented, and the new mapping applies from the next access on.

Top module: `bank_mmu`

## Requirements
- R1: The active code bank is status bits 6:4; flag bits 3:0 and bit 7 play no part in it. An instruction fetch (kind 2'b00) always reads that bank at offset = address, in every mode and whatever the steering register holds.
- R2: With code bank 0-3 (system mode) and the steering register at 0, a data read (kind 2'b01) or data write (kind 2'b10) at any offset other than 0xFF goes to physical bank 8.
- R3: With code bank 4-7 (user mode), fetches, data reads and data writes all go to the active code bank at offset = address.
- R4: A constant load (kind 2'b11) reads the active code bank, in system mode as well as user mode, including offset 0xFF.
- R5: In system mode, a data write at offset 0xFF stores the write data in the steering register instead of memory. The hit output is 1, the memory write strobe stays 0, and the new value governs accesses from the next cycle on.
- R6: Steering encoding for system-mode data accesses: value 1 selects bank 9 (I/O page); values 4, 5, 6 and 7 select that user bank; 0 and every other value select bank 8.
- R7: In system mode, a data read at offset 0xFF returns the steering register on the register-data output with hit = 1 and the memory read strobe at 0. In every other case the register-data output is 0.
- R8: In user mode, a data access at offset 0xFF goes to the user bank as plain memory with hit = 0, and the steering register is left unchanged.
- R9: Reset clears the steering register to 0.
- R10: Writing 0 to the steering register sends later system-mode data accesses back to bank 8.
- R11: When no access is valid, both memory strobes and the hit output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ps_i | input | 8 | Processor status byte; bits 6:4 select the code bank |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_kind_i | input | 2 | 00 fetch, 01 data read, 10 data write, 11 constant load |
| addr_i | input | 8 | Address from the core |
| wdata_i | input | 8 | Write data from the core |
| bank_o | output | 4 | Physical bank: 0-7 code/user, 8 system data, 9 I/O page |
| offset_o | output | 8 | Offset inside the physical bank |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| vbr_hit_o | output | 1 | The access targets the steering register |
| vbr_rdata_o | output | 8 | Steering register contents on a register read |

## Verification
Bank, offset, strobes, hit and register-data outputs depend only on the current inputs and the stored steering value, so they are due in the same cycle as the access. The scoreboard samples them one nanosecond after the driving falling edge, well before the next rising edge. A write to the steering register lands on the next rising edge. The bench's reference model therefore updates its copy of the register only after it has queued the expectation for that write, so the first access that uses the new value is the following one. The checks for "register unchanged" read the register back through the normal system-mode read at offset 0xFF.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10,
      ACC_CONST = 2'b11
   } acc_kind_e;
endpackage

// File: rtl/bank_mmu_mode.sv
// Extracts the active code bank from the status byte and classifies it.
module bank_mmu_mode #(
   parameter int DATA_W    = 8,
   parameter int SEL_LSB   = 4,
   parameter int SEL_W     = 3,
   parameter int SYS_BANKS = 4
) (
   input  logic [DATA_W-1:0] ps_i,
   output logic [SEL_W-1:0]  code_bank_o,
   output logic              sys_mode_o
);
   localparam int NUM_CODE = 1 << SEL_W;

   if (SEL_LSB + SEL_W > DATA_W) begin : g_bad_field
      $error("bank selector field exceeds status width");
   end
   if (SYS_BANKS < 1 || SYS_BANKS >= NUM_CODE) begin : g_bad_split
      $error("system bank count must leave at least one user bank");
   end

   assign code_bank_o = ps_i[SEL_LSB +: SEL_W];
   assign sys_mode_o  = ({1'b0, code_bank_o} < (SEL_W+1)'(SYS_BANKS));
endmodule

// File: rtl/bank_mmu_vbr.sv
// Steering register with its decode into a physical data bank.
module bank_mmu_vbr #(
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 3,
   parameter int BANK_W      = 4,
   parameter int SYS_BANKS   = 4,
   parameter int OS_BANK     = 8,
   parameter int IO_BANK     = 9,
   parameter int IO_CODE     = 1,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] vbr_q_o,
   output logic [BANK_W-1:0] target_o
);
   localparam int NUM_CODE = 1 << SEL_W;
   localparam int KEY_W    = FULL_DECODE ? DATA_W : SEL_W;

   if (IO_BANK >= (1 << BANK_W) || OS_BANK >= (1 << BANK_W)) begin : g_bad_bank
      $error("bank width too narrow for system data or I/O bank");
   end
   if (IO_CODE >= SYS_BANKS || IO_CODE == 0) begin : g_bad_io
      $error("I/O code must be nonzero and outside the user range");
   end

   logic [DATA_W-1:0] vbr_q;
   logic [KEY_W-1:0]  key;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vbr_q <= '0;
      else if (wr_en_i) vbr_q <= wdata_i;
   end

   // Variant: compare the whole byte, or only the selector-wide low part.
   if (FULL_DECODE) begin : g_full_key
      assign key = vbr_q;
   end else begin : g_short_key
      assign key = vbr_q[SEL_W-1:0];
   end

   logic [NUM_CODE-1:0] user_hit;
   for (genvar u = 0; u < NUM_CODE; u++) begin : g_user
      if (u >= SYS_BANKS) begin : g_match
         assign user_hit[u] = (key == KEY_W'(u));
      end else begin : g_none
         assign user_hit[u] = 1'b0;
      end
   end

   always_comb begin
      target_o = BANK_W'(OS_BANK);
      if (key == KEY_W'(IO_CODE)) target_o = BANK_W'(IO_BANK);
      for (int u = 0; u < NUM_CODE; u++) begin
         if (user_hit[u]) target_o = BANK_W'(u);
      end
   end

   assign vbr_q_o = vbr_q;
endmodule

// File: rtl/bank_mmu_route.sv
// Chooses the physical bank per access kind and separates register hits.
module bank_mmu_route
   import bank_mmu_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SEL_W  = 3,
   parameter int BANK_W = 4
) (
   input  logic              valid_i,
   input  acc_kind_e         kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SEL_W-1:0]  code_bank_i,
   input  logic              sys_mode_i,
   input  logic [BANK_W-1:0] data_target_i,
   output logic [BANK_W-1:0] bank_o,
   output logic [ADDR_W-1:0] offset_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              reg_hit_o,
   output logic              reg_wr_o,
   output logic              reg_rd_o
);
   localparam logic [ADDR_W-1:0] REG_ADDR = '1;

   if (BANK_W <= SEL_W) begin : g_bad_width
      $error("physical bank width must exceed selector width");
   end

   logic is_data;
   logic is_write;

   always_comb begin
      is_data  = (kind_i == ACC_READ) || (kind_i == ACC_WRITE);
      is_write = (kind_i == ACC_WRITE);
      if (is_data && sys_mode_i) bank_o = data_target_i;
      else                       bank_o = BANK_W'(code_bank_i);
      offset_o  = addr_i;
      reg_hit_o = valid_i && sys_mode_i && is_data && (addr_i == REG_ADDR);
      reg_wr_o  = reg_hit_o && is_write;
      reg_rd_o  = reg_hit_o && !is_write;
      mem_wr_o  = valid_i && is_write && !reg_hit_o;
      mem_rd_o  = valid_i && !is_write && !reg_hit_o;
   end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
   import bank_mmu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int SEL_LSB     = 4,
   parameter int SEL_W       = 3,
   parameter int SYS_BANKS   = 4,
   parameter int BANK_W      = 4,
   parameter int OS_BANK     = 8,
   parameter int IO_BANK     = 9,
   parameter int IO_CODE     = 1,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ps_i,
   input  logic              acc_valid_i,
   input  logic [1:0]        acc_kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [BANK_W-1:0] bank_o,
   output logic [ADDR_W-1:0] offset_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              vbr_hit_o,
   output logic [DATA_W-1:0] vbr_rdata_o
);
   logic [SEL_W-1:0]  code_bank;
   logic              sys_mode;
   logic [DATA_W-1:0] vbr_q;
   logic [BANK_W-1:0] data_target;
   logic              reg_wr;
   logic              reg_rd;
   acc_kind_e         kind;

   assign kind = acc_kind_e'(acc_kind_i);

   bank_mmu_mode #(
      .DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .SYS_BANKS(SYS_BANKS)
   ) u_mode (
      .ps_i(ps_i), .code_bank_o(code_bank), .sys_mode_o(sys_mode)
   );

   bank_mmu_vbr #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .BANK_W(BANK_W), .SYS_BANKS(SYS_BANKS),
      .OS_BANK(OS_BANK), .IO_BANK(IO_BANK), .IO_CODE(IO_CODE),
      .FULL_DECODE(FULL_DECODE)
   ) u_vbr (
      .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr), .wdata_i(wdata_i),
      .vbr_q_o(vbr_q), .target_o(data_target)
   );

   bank_mmu_route #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BANK_W(BANK_W)
   ) u_route (
      .valid_i(acc_valid_i), .kind_i(kind), .addr_i(addr_i),
      .code_bank_i(code_bank), .sys_mode_i(sys_mode),
      .data_target_i(data_target), .bank_o(bank_o), .offset_o(offset_o),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .reg_hit_o(vbr_hit_o),
      .reg_wr_o(reg_wr), .reg_rd_o(reg_rd)
   );

   assign vbr_rdata_o = reg_rd ? vbr_q : '0;
endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int SEL_LSB   = 4,
   parameter int SEL_W     = 3,
   parameter int SYS_BANKS = 4,
   parameter int BANK_W    = 4,
   parameter int OS_BANK   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] ps_i,
   input logic              acc_valid_i,
   input logic [1:0]        acc_kind_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [BANK_W-1:0] bank_o,
   input logic [ADDR_W-1:0] offset_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic              vbr_hit_o
);
   localparam logic [ADDR_W-1:0] TOP = '1;
   logic [SEL_W-1:0] sel;
   logic             user;
   logic             data;
   assign sel  = ps_i[SEL_LSB +: SEL_W];
   assign user = ({1'b0, sel} >= (SEL_W+1)'(SYS_BANKS));
   assign data = (acc_kind_i == 2'b01) || (acc_kind_i == 2'b10);

   assert_user_same_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && user |-> bank_o == BANK_W'(sel) && offset_o == addr_i);

   assert_const_code_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && acc_kind_i == 2'b11 |-> bank_o == BANK_W'(sel));

   assert_fetch_code_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && acc_kind_i == 2'b00 |-> bank_o == BANK_W'(sel) && !vbr_hit_o);

   assert_reg_write_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vbr_hit_o |-> !mem_wr_o && !mem_rd_o);

   assert_user_top_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && user && data && addr_i == TOP |-> !vbr_hit_o);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid_i |-> !mem_rd_o && !mem_wr_o && !vbr_hit_o);

   assert_zero_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(vbr_hit_o && acc_kind_i == 2'b10 && wdata_i == '0)
      && acc_valid_i && !user && data && addr_i != TOP
      |-> bank_o == BANK_W'(OS_BANK));
endmodule

bind bank_mmu bank_mmu_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W),
   .SYS_BANKS(SYS_BANKS), .BANK_W(BANK_W), .OS_BANK(OS_BANK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ps_i(ps_i), .acc_valid_i(acc_valid_i),
   .acc_kind_i(acc_kind_i), .addr_i(addr_i), .wdata_i(wdata_i),
   .bank_o(bank_o), .offset_o(offset_o), .mem_rd_o(mem_rd_o),
   .mem_wr_o(mem_wr_o), .vbr_hit_o(vbr_hit_o)
);

// File: tb/tb_bank_mmu.sv
`timescale 1ns/1ps
module tb_bank_mmu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ps = 8'h00;
   logic       valid = 1'b0;
   logic [1:0] kind = 2'b00;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [3:0] bank;
   logic [7:0] off;
   logic       mrd, mwr, hit;
   logic [7:0] rdata;

   always #2.5 clk = ~clk;

   bank_mmu dut (
      .clk(clk), .rst_n(rst_n), .ps_i(ps), .acc_valid_i(valid),
      .acc_kind_i(kind), .addr_i(addr), .wdata_i(wdata), .bank_o(bank),
      .offset_o(off), .mem_rd_o(mrd), .mem_wr_o(mwr), .vbr_hit_o(hit),
      .vbr_rdata_o(rdata)
   );

   typedef struct {
      logic [3:0] bank;
      logic [7:0] off;
      logic       rd, wr, hit;
      logic [7:0] rdata;
      bit         cmp_addr;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   logic [7:0] model_vbr = 8'h00;

   // Reference model built from the requirements.
   task automatic access(input logic [7:0] p, input logic v, input logic [1:0] k,
                         input logic [7:0] a, input logic [7:0] d, input string tag);
      exp_t e;
      logic [2:0] sel;
      logic       sys, dat;
      logic [3:0] tgt;
      @(negedge clk);
      ps = p; valid = v; kind = k; addr = a; wdata = d;
      sel = p[6:4];
      sys = (sel < 3'd4);
      dat = (k == 2'b01) || (k == 2'b10);
      case (model_vbr)
         8'd1: tgt = 4'd9;
         8'd4, 8'd5, 8'd6, 8'd7: tgt = model_vbr[3:0];
         default: tgt = 4'd8;
      endcase
      e.tag = tag;
      e.cmp_addr = v;
      e.off = a;
      e.bank = (dat && sys) ? tgt : {1'b0, sel};
      e.hit = v && sys && dat && (a == 8'hFF);
      e.wr = v && (k == 2'b10) && !e.hit;
      e.rd = v && (k != 2'b10) && !e.hit;
      e.rdata = (e.hit && k == 2'b01) ? model_vbr : 8'h00;
      exp_q.push_back(e);
      if (e.hit && k == 2'b10) model_vbr = d;
   endtask

   // Monitor: compare results in the cycle the access is presented.
   always begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if ((e.cmp_addr && (bank !== e.bank || off !== e.off)) ||
             mrd !== e.rd || mwr !== e.wr || hit !== e.hit || rdata !== e.rdata) begin
            failures++;
            $display("FAIL %s: got bank=%0d off=%02h rd=%b wr=%b hit=%b rdata=%02h, expected bank=%0d off=%02h rd=%b wr=%b hit=%b rdata=%02h",
                     e.tag, bank, off, mrd, mwr, hit, rdata,
                     e.bank, e.off, e.rd, e.wr, e.hit, e.rdata);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R9 / R7: register reads back zero after reset
      access(8'h00, 1, 2'b01, 8'hFF, 8'h00, "R9");
      // R1: fetch uses status bits 6:4, flags ignored
      access(8'h2F, 1, 2'b00, 8'h10, 8'h00, "R1");
      access(8'hFF, 1, 2'b00, 8'h33, 8'h00, "R1");
      // R2: system data read/write to bank 8
      access(8'h10, 1, 2'b01, 8'h20, 8'h00, "R2");
      access(8'h30, 1, 2'b10, 8'hFE, 8'h5A, "R2");
      // R4: constant load from code bank, also at 0xFF
      access(8'h30, 1, 2'b11, 8'h40, 8'h00, "R4");
      access(8'h10, 1, 2'b11, 8'hFF, 8'h00, "R4");
      access(8'h60, 1, 2'b11, 8'h07, 8'h00, "R4");
      // R3: user mode shares one bank
      access(8'h5F, 1, 2'b00, 8'h01, 8'h00, "R3");
      access(8'h50, 1, 2'b01, 8'h80, 8'h00, "R3");
      access(8'h50, 1, 2'b10, 8'h81, 8'hA5, "R3");
      // R8: user offset 0xFF is memory; register unchanged
      access(8'h50, 1, 2'b10, 8'hFF, 8'h01, "R8");
      access(8'h70, 1, 2'b01, 8'hFF, 8'h00, "R8");
      access(8'h00, 1, 2'b01, 8'hFF, 8'h00, "R8");
      // R5 / R6: steer to I/O page
      access(8'h00, 1, 2'b10, 8'hFF, 8'h01, "R5");
      access(8'h00, 1, 2'b01, 8'h30, 8'h00, "R6");
      access(8'h20, 1, 2'b10, 8'h31, 8'h11, "R6");
      access(8'h00, 1, 2'b01, 8'hFF, 8'h00, "R7");
      // R1: fetch ignores steering
      access(8'h10, 1, 2'b00, 8'h05, 8'h00, "R1");
      // R6: user banks and unused codes
      access(8'h00, 1, 2'b10, 8'hFF, 8'h06, "R5");
      access(8'h00, 1, 2'b01, 8'h44, 8'h00, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h04, "R5");
      access(8'h30, 1, 2'b10, 8'h45, 8'h22, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h07, "R5");
      access(8'h00, 1, 2'b01, 8'h46, 8'h00, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h02, "R5");
      access(8'h00, 1, 2'b01, 8'h47, 8'h00, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h85, "R5");
      access(8'h00, 1, 2'b01, 8'h48, 8'h00, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h14, "R5");
      access(8'h00, 1, 2'b01, 8'h49, 8'h00, "R6");
      access(8'h00, 1, 2'b01, 8'hFF, 8'h00, "R7");
      // R10: zero restores system data bank
      access(8'h00, 1, 2'b10, 8'hFF, 8'h05, "R5");
      access(8'h00, 1, 2'b01, 8'h50, 8'h00, "R6");
      access(8'h00, 1, 2'b10, 8'hFF, 8'h00, "R10");
      access(8'h30, 1, 2'b01, 8'h51, 8'h00, "R10");
      // R11: idle cycles are quiet
      access(8'h00, 0, 2'b10, 8'hFF, 8'h06, "R11");
      access(8'h50, 0, 2'b01, 8'h10, 8'h00, "R11");
      access(8'h00, 1, 2'b01, 8'hFF, 8'h00, "R11");
      @(negedge clk) valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule